// File: doc/BRIEF.md
# Select-Steered Reversible Bitwise Logic Unit

This block computes bitwise Boolean functions of two operand words. Each bit is handled by its own slice. A slice holds one four-in/four-out reversible cell, which maps its input codes one-to-one onto its output codes. It also holds one two-in/two-out controlled-inversion gate.

The two select bits are not decoded by a multiplexer. They enter every cell as two of its four data inputs. As a result, several functions come out of each cell at once on separate wires:

- The primary output depends on the select value.
- A second output depends on the select value in a different way.
- A third output carries the complement of A when the select is 11.
- The exclusive-OR is present whatever the select value.

The controlled-inversion gate takes the exclusive-OR line against a constant one. This gives the exclusive-OR and its complement side by side, so no wire drives two gate inputs.

All five result vectors are captured in one register stage. That stage is cleared by a synchronous active-high reset. A user drives the operands and the select, then reads the results one clock later.

Top module: `rlu_top`

## Requirements
- R1: While `rst` is high at a rising clock edge, every output vector is zero after that edge.
- R2: Outputs change only at rising edges and always reflect the operands and select sampled at the previous rising edge (one cycle of latency).
- R3: With select 2'b00, `res_main` equals A AND B and `res_aux` is all zeros.
- R4: With select 2'b01, `res_main` equals NOT (A AND B) and `res_aux` is all ones.
- R5: With select 2'b10, `res_main` equals A OR B and `res_aux` equals NOT (A XOR B).
- R6: With select 2'b11, `res_inv` equals NOT A, `res_main` equals A AND B and `res_aux` equals A XOR B.
- R7: With any select other than 2'b11, `res_inv` equals A unchanged.
- R8: `res_xor` equals A XOR B and `res_xnor` equals its bitwise complement for every select value.
- R9: The per-bit cell is reversible. Its input code is {a,b,sel[1],sel[0]} with `a` as the most significant bit, and its output code is {inv,xor,aux,main}. All 16 input codes give 16 distinct output codes.
- R10: Bit i of every output depends only on bit i of A, bit i of B and the select, so a single set operand bit affects no other bit position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | WIDTH | Operand A |
| op_b | input | WIDTH | Operand B |
| sel | input | 2 | Function select, fed into every cell as data |
| res_main | output | WIDTH | Select-dependent primary result |
| res_aux | output | WIDTH | Select-dependent secondary result |
| res_inv | output | WIDTH | NOT A when select is 11, else A |
| res_xor | output | WIDTH | A XOR B, select-independent |
| res_xnor | output | WIDTH | A XNOR B, select-independent |

## Verification
The bench drives all 16 codes into a standalone cell. A cell whose map folds two codes together would show a repeated output code. For every select value, random and walking-one operands are compared against a behavioural reference on all five vectors. These comparisons catch three classes of fault:

- A swapped select decode, which shows up as a NAND where an AND was expected.
- A secondary output that leaks across selects.
- An inverter output that fails to pass A through for the first three selects.

A reset asserted in the middle of a run with non-zero operands must clear everything. The exclusive-OR pair is checked under every select, so an exclusive-OR line accidentally gated by the select cannot escape.

// File: rtl/rlu_pkg.sv
package rlu_pkg;

    parameter int unsigned RLU_WIDTH = 16;

    typedef enum logic [1:0] {
        SEL_AND  = 2'b00,
        SEL_NAND = 2'b01,
        SEL_OR   = 2'b10,
        SEL_INV  = 2'b11
    } rlu_sel_e;

    // One cell's four input lines, MSB first as in the code ordering.
    typedef struct packed {
        logic a;
        logic b;
        logic c;
        logic d;
    } cell_in_t;

    // One cell's four output lines: inverter, exclusive-OR, aux, main.
    typedef struct packed {
        logic p;
        logic q;
        logic r;
        logic s;
    } cell_out_t;

    // Main output of the cell: chosen per select code, with the code 11
    // reusing the AND term so that the full map stays one-to-one.
    function automatic logic cell_main(input logic a, input logic b,
                                       input logic c, input logic d);
        logic and_t;
        and_t = a & b;
        case ({c, d})
            2'b01:   return ~and_t;
            2'b10:   return a | b;
            default: return and_t;
        endcase
    endfunction

    // Aux output: the low select bit, flipped by the equality term when
    // the high select bit is set.
    function automatic logic cell_aux(input logic a, input logic b,
                                      input logic c, input logic d);
        return d ^ (c & ~(a ^ b));
    endfunction

endpackage

// File: rtl/rlu_gate4.sv
module rlu_gate4
    import rlu_pkg::*;
(
    input  cell_in_t  x,
    output cell_out_t y
);

    logic both_sel;

    assign both_sel = x.c & x.d;

    always_comb begin
        y.p = x.a ^ both_sel;
        y.q = x.a ^ x.b;
        y.r = cell_aux(x.a, x.b, x.c, x.d);
        y.s = cell_main(x.a, x.b, x.c, x.d);
    end

endmodule

// File: rtl/rlu_fan2.sv
module rlu_fan2 (
    input  logic ctl,
    input  logic tgt,
    output logic ctl_o,
    output logic tgt_o
);

    assign ctl_o = ctl;
    assign tgt_o = ctl ^ tgt;

endmodule

// File: rtl/rlu_slice.sv
module rlu_slice
    import rlu_pkg::*;
#(
    parameter logic TGT_CONST = 1'b1
) (
    input  logic       a,
    input  logic       b,
    input  logic [1:0] sel,
    output logic       o_main,
    output logic       o_aux,
    output logic       o_inv,
    output logic       o_xor,
    output logic       o_xnor
);

    cell_in_t  cin;
    cell_out_t cout;

    assign cin = '{a: a, b: b, c: sel[1], d: sel[0]};

    rlu_gate4 u_cell (
        .x (cin),
        .y (cout)
    );

    // The exclusive-OR line is consumed only by this gate, which hands out
    // the line itself and its inversion against the constant target.
    rlu_fan2 u_fan (
        .ctl   (cout.q),
        .tgt   (TGT_CONST),
        .ctl_o (o_xor),
        .tgt_o (o_xnor)
    );

    assign o_main = cout.s;
    assign o_aux  = cout.r;
    assign o_inv  = cout.p;

endmodule

// File: rtl/rlu_top.sv
module rlu_top
    import rlu_pkg::*;
#(
    parameter int unsigned WIDTH = RLU_WIDTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic [1:0]       sel,
    output logic [WIDTH-1:0] res_main,
    output logic [WIDTH-1:0] res_aux,
    output logic [WIDTH-1:0] res_inv,
    output logic [WIDTH-1:0] res_xor,
    output logic [WIDTH-1:0] res_xnor
);

    localparam int unsigned NUM_GATES = 2 * WIDTH;

    logic [WIDTH-1:0] w_main;
    logic [WIDTH-1:0] w_aux;
    logic [WIDTH-1:0] w_inv;
    logic [WIDTH-1:0] w_xor;
    logic [WIDTH-1:0] w_xnor;

    for (genvar i = 0; i < WIDTH; i++) begin : g_slice
        rlu_slice #(
            .TGT_CONST (1'b1)
        ) u_slice (
            .a      (op_a[i]),
            .b      (op_b[i]),
            .sel    (sel),
            .o_main (w_main[i]),
            .o_aux  (w_aux[i]),
            .o_inv  (w_inv[i]),
            .o_xor  (w_xor[i]),
            .o_xnor (w_xnor[i])
        );
    end

    initial begin
        if (NUM_GATES != 2 * WIDTH) $display("gate count mismatch");
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_main <= '0;
            res_aux  <= '0;
            res_inv  <= '0;
            res_xor  <= '0;
            res_xnor <= '0;
        end else begin
            res_main <= w_main;
            res_aux  <= w_aux;
            res_inv  <= w_inv;
            res_xor  <= w_xor;
            res_xnor <= w_xnor;
        end
    end

endmodule

// File: rtl/rlu_top_chk.sv
module rlu_top_chk #(
    parameter int unsigned WIDTH = 16
) (
    input logic             clk,
    input logic             rst,
    input logic [WIDTH-1:0] op_a,
    input logic [WIDTH-1:0] op_b,
    input logic [1:0]       sel,
    input logic [WIDTH-1:0] res_main,
    input logic [WIDTH-1:0] res_aux,
    input logic [WIDTH-1:0] res_inv,
    input logic [WIDTH-1:0] res_xor,
    input logic [WIDTH-1:0] res_xnor
);

    logic live;

    always_ff @(posedge clk) begin
        if (rst) live <= 1'b0;
        else     live <= 1'b1;
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (res_main == '0 && res_aux == '0 && res_inv == '0 &&
                 res_xor == '0 && res_xnor == '0));

    assert_and_sel_R3: assert property (@(posedge clk) disable iff (rst)
        (live == 1'b1 && $past(sel) == 2'b00) |->
        (res_main == ($past(op_a) & $past(op_b)) && res_aux == '0));

    assert_nand_sel_R4: assert property (@(posedge clk) disable iff (rst)
        (live == 1'b1 && $past(sel) == 2'b01) |->
        (res_main == ~($past(op_a) & $past(op_b)) && res_aux == '1));

    assert_or_sel_R5: assert property (@(posedge clk) disable iff (rst)
        (live == 1'b1 && $past(sel) == 2'b10) |->
        (res_main == ($past(op_a) | $past(op_b)) &&
         res_aux == ~($past(op_a) ^ $past(op_b))));

    assert_inv_sel_R6: assert property (@(posedge clk) disable iff (rst)
        (live == 1'b1 && $past(sel) == 2'b11) |->
        (res_inv == ~$past(op_a) && res_aux == res_xor));

    assert_inv_pass_R7: assert property (@(posedge clk) disable iff (rst)
        (live == 1'b1 && $past(sel) != 2'b11) |-> (res_inv == $past(op_a)));

    assert_xor_pair_R8: assert property (@(posedge clk) disable iff (rst)
        live == 1'b1 |->
        (res_xor == ($past(op_a) ^ $past(op_b)) && res_xnor == ~res_xor));

    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (live == 1'b1 && $stable(op_a) && $stable(op_b) && $stable(sel)) |=>
        $stable(res_main));

endmodule

bind rlu_top rlu_top_chk #(.WIDTH(WIDTH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .op_a     (op_a),
    .op_b     (op_b),
    .sel      (sel),
    .res_main (res_main),
    .res_aux  (res_aux),
    .res_inv  (res_inv),
    .res_xor  (res_xor),
    .res_xnor (res_xnor)
);

// File: tb/rlu_top_tb.sv
`timescale 1ns/1ps
module rlu_top_tb;
    import rlu_pkg::*;

    localparam int W = 16;

    typedef struct {
        logic [W-1:0] m;
        logic [W-1:0] aux;
        logic [W-1:0] inv;
        logic [W-1:0] x;
        logic [W-1:0] xn;
        logic [1:0]   s;
        logic         was_rst;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] op_a = '0;
    logic [W-1:0] op_b = '0;
    logic [1:0]   sel = 2'b00;
    logic [W-1:0] res_main, res_aux, res_inv, res_xor, res_xnor;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;
    exp_t q_exp[$];

    cell_in_t  c_in;
    cell_out_t c_out;

    always #2.5 clk = ~clk;

    rlu_top #(.WIDTH(W)) u_dut (
        .clk      (clk),
        .rst      (rst),
        .op_a     (op_a),
        .op_b     (op_b),
        .sel      (sel),
        .res_main (res_main),
        .res_aux  (res_aux),
        .res_inv  (res_inv),
        .res_xor  (res_xor),
        .res_xnor (res_xnor)
    );

    rlu_gate4 u_cell (
        .x (c_in),
        .y (c_out)
    );

    function automatic exp_t model(input logic [W-1:0] a, input logic [W-1:0] b,
                                   input logic [1:0] s, input logic r);
        exp_t e;
        e.s = s;
        e.was_rst = r;
        if (r) begin
            e.m = '0; e.aux = '0; e.inv = '0; e.x = '0; e.xn = '0;
            return e;
        end
        e.x  = a ^ b;
        e.xn = ~(a ^ b);
        e.inv = (s == 2'b11) ? ~a : a;
        case (s)
            2'b00: begin e.m = a & b;    e.aux = '0;      end
            2'b01: begin e.m = ~(a & b); e.aux = '1;      end
            2'b10: begin e.m = a | b;    e.aux = ~(a ^ b); end
            default: begin e.m = a & b; e.aux = a ^ b;   end
        endcase
        return e;
    endfunction

    task automatic cmp(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_out(input exp_t e);
        string tm, ta, ti;
        if (e.was_rst) begin
            tm = "R1 main"; ta = "R1 aux"; ti = "R1 inv";
        end else begin
            case (e.s)
                2'b00: begin tm = "R2/R3 main"; ta = "R3 aux"; ti = "R7 inv"; end
                2'b01: begin tm = "R2/R4 main"; ta = "R4 aux"; ti = "R7 inv"; end
                2'b10: begin tm = "R2/R5 main"; ta = "R5 aux"; ti = "R7 inv"; end
                default: begin tm = "R2/R6 main"; ta = "R6 aux"; ti = "R6 inv"; end
            endcase
        end
        cmp(tm, res_main, e.m);
        cmp(ta, res_aux, e.aux);
        cmp(ti, res_inv, e.inv);
        cmp(e.was_rst ? "R1 xor" : "R8 xor", res_xor, e.x);
        cmp(e.was_rst ? "R1 xnor" : "R8 xnor", res_xnor, e.xn);
    endtask

    // Each call: check what the previous call launched, then launch new inputs.
    task automatic step(input logic [W-1:0] a, input logic [W-1:0] b,
                        input logic [1:0] s, input logic r);
        @(negedge clk);
        if (q_exp.size() > 0) check_out(q_exp.pop_front());
        op_a = a; op_b = b; sel = s; rst = r;
        q_exp.push_back(model(a, b, s, r));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #200000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [15:0] seen;
        // R9: reversibility of the cell, all 16 input codes.
        seen = '0;
        for (int k = 0; k < 16; k++) begin
            c_in = cell_in_t'(k[3:0]);
            #1;
            seen[c_out] = 1'b1;
        end
        n_chk++;
        if (seen !== 16'hFFFF) begin
            n_bad++;
            $display("FAIL R9 cell codes actual=%h expected=%h", seen, 16'hFFFF);
        end

        // R1: reset state with non-zero operands present.
        step(16'hFFFF, 16'h1234, 2'b01, 1'b1);
        step(16'hA5A5, 16'h0F0F, 2'b10, 1'b1);

        // Fixed patterns across every select value.
        for (int s = 0; s < 4; s++) begin
            step(16'h0000, 16'h0000, s[1:0], 1'b0);
            step(16'hFFFF, 16'hFFFF, s[1:0], 1'b0);
            step(16'hFF00, 16'hF0F0, s[1:0], 1'b0);
            step(16'h5555, 16'hAAAA, s[1:0], 1'b0);
        end

        // R10: walking single bits on each operand, every select.
        for (int s = 0; s < 4; s++) begin
            for (int i = 0; i < W; i++) begin
                step(W'(1) << i, '0, s[1:0], 1'b0);
                step('0, W'(1) << i, s[1:0], 1'b0);
            end
        end

        // Random operands under every select, including back-to-back changes.
        for (int k = 0; k < 400; k++) begin
            step(W'($urandom), W'($urandom), 2'($urandom), 1'b0);
        end

        // R1: reset in the middle of a run, then recovery.
        step(16'hDEAD, 16'hBEEF, 2'b11, 1'b1);
        step(16'hDEAD, 16'hBEEF, 2'b11, 1'b0);
        step(16'h8001, 16'h7FFE, 2'b00, 1'b0);
        step('0, '0, 2'b00, 1'b0);
        @(negedge clk);
        if (q_exp.size() > 0) check_out(q_exp.pop_front());
        finish_run();
    end

endmodule